// File: doc/BRIEF.md
# Configurable Asynchronous Frame Transmitter

This block turns one parallel byte at a time into an asynchronous serial frame on a single line. A three-bit format code sets the frame shape: 7 or 8 data bits, an optional parity bit, and one or two stop bits. Both widths and the parity option can be chosen independently, so the code selects one of eight layouts.

A multiprocessor mode can be turned on for each frame. In that mode the bit after the data is no longer parity. It is a flag bit chosen by software, which receivers use to tell address frames from data frames. Bit timing comes from an outside divider, which supplies a one-cycle enable pulse once per bit time. The block reports whether a frame is in progress, and whether it can accept a new byte.

Top module: `frame_tx`

## Requirements
- R1: After reset the line `txd` is high, `busy` is low and `tx_empty` is high. Whenever `busy` is low the line is high.
- R2: `fmt_sel[2]` = 1 sends all 8 data bits. When it is 0, only the low 7 bits are sent and bit 7 of the byte does not appear on the line.
- R3: `fmt_sel[1]` = 1 with `mp_en` = 0 adds a parity bit after the data. With `par_odd` = 0 the parity is even: the sent data bits plus the parity bit hold an even number of ones. With `par_odd` = 1 the count is odd.
- R4: `fmt_sel[0]` = 1 sends two stop bits. When it is 0, one stop bit is sent.
- R5: The frame order is a low start bit, then the data bits least significant bit first, then the parity or flag bit if present, then high stop bits.
- R6: When `mp_en` = 1, the bit after the data equals `mp_flag`, and no parity bit is sent whatever `fmt_sel[1]` holds.
- R7: In multiprocessor mode, `fmt_sel[2]` still selects the data width and `fmt_sel[0]` still selects the stop count.
- R8: `txd` changes only on the clock edge where `bit_tick` is high. The first tick after a load drives the start bit, and each later tick drives the next bit, so each bit lasts exactly one tick interval.
- R9: `busy` goes high in the cycle after an accepted `load`. It goes low on the tick that follows the tick that drove the last stop bit. `tx_empty` is always the inverse of `busy`.
- R10: A `load` pulse while `busy` is high is ignored. The frame in progress goes out unchanged, and no second frame follows it.
- R11: The byte, format code, `mp_en`, `mp_flag` and `par_odd` are sampled on the accepted load. Changing them during the frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load | input | 1 | Load strobe for `load_data` and the settings |
| load_data | input | DATA_W | Byte to send |
| fmt_sel | input | 3 | Format code: [2] width, [1] parity enable, [0] stop count |
| mp_en | input | 1 | Multiprocessor mode enable |
| mp_flag | input | 1 | Value of the multiprocessor flag bit |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| txd | output | 1 | Serial line, idles high |
| busy | output | 1 | Frame in progress |
| tx_empty | output | 1 | Ready for a new byte |

## Verification
The bench walks all eight format codes and reads the line bit by bit after each tick, so a wrong width, a missing parity bit or a lost stop bit shows up as a length or bit miscompare. Bytes with bit 7 set are sent in 7-bit mode, where a design that leaked the top bit would put it where parity or stop should be. Multiprocessor frames are sent with the parity-enable bit set, which catches a design that still inserts parity or gets the flag polarity wrong. Mid-frame loads and mid-frame setting changes catch a design that reloads its shifter or reads the live inputs instead of the captured ones. Idle cycles between ticks catch a line that moves without a tick.

// File: rtl/frame_tx_pkg.sv
package frame_tx_pkg;

   // Decoded frame-format code
   typedef struct packed {
      logic wide;      // 1: full data width, 0: one bit fewer
      logic par_en;    // parity bit after data
      logic two_stop;  // 1: two stop bits
   } fmt_t;

   function automatic fmt_t decode_fmt(input logic [2:0] code);
      fmt_t f;
      f.wide     = code[2];
      f.par_en   = code[1];
      f.two_stop = code[0];
      return f;
   endfunction

endpackage

// File: rtl/frame_tx_parity.sv
module frame_tx_parity #(
   parameter int W     = 8,
   parameter bit CHAIN = 1'b0   // 0: reduction tree, 1: ripple chain
) (
   input  logic [W-1:0] bits,
   input  logic [W-1:0] mask,
   input  logic         odd,
   output logic         par
);

   logic [W-1:0] sel;
   assign sel = bits & mask;

   generate
      if (CHAIN) begin : g_chain
         logic [W:0] acc;
         assign acc[0] = odd;
         for (genvar i = 0; i < W; i++) begin : g_stage
            assign acc[i+1] = acc[i] ^ sel[i];
         end
         assign par = acc[W];
      end else begin : g_tree
         assign par = odd ^ (^sel);
      end
   endgenerate

endmodule

// File: rtl/frame_tx_build.sv
module frame_tx_build
   import frame_tx_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter bit PAR_CHAIN = 1'b0,
   parameter int FRAME_W   = DATA_W + 4,
   parameter int LEN_W     = $clog2(FRAME_W + 1)
) (
   input  logic [DATA_W-1:0]  data,
   input  fmt_t               fmt,
   input  logic               mp_en,
   input  logic               mp_flag,
   input  logic               par_odd,
   output logic [FRAME_W-1:0] frame,
   output logic [LEN_W-1:0]   len
);

   logic [LEN_W-1:0]  dw;
   logic [LEN_W-1:0]  xpos;
   logic              xen;
   logic              xval;
   logic              par;
   logic [DATA_W-1:0] mask;

   assign dw   = fmt.wide ? LEN_W'(DATA_W) : LEN_W'(DATA_W - 1);
   assign xen  = mp_en | fmt.par_en;
   assign xpos = dw + LEN_W'(1);

   // Only the data bits that go on the line enter the parity
   generate
      for (genvar i = 0; i < DATA_W; i++) begin : g_mask
         if (i < DATA_W - 1) begin : g_low
            assign mask[i] = 1'b1;
         end else begin : g_top
            assign mask[i] = fmt.wide;
         end
      end
   endgenerate

   frame_tx_parity #(
      .W     (DATA_W),
      .CHAIN (PAR_CHAIN)
   ) u_par (
      .bits (data),
      .mask (mask),
      .odd  (par_odd),
      .par  (par)
   );

   // Flag replaces parity in multiprocessor mode
   assign xval = mp_en ? mp_flag : par;

   // Position 0 is the start bit; everything past the extra bit is stop/idle
   assign frame[0] = 1'b0;
   generate
      for (genvar j = 1; j < FRAME_W; j++) begin : g_pos
         if (j <= DATA_W) begin : g_data
            assign frame[j] = (LEN_W'(j) <= dw) ? data[j-1]
                            : ((xen && (LEN_W'(j) == xpos)) ? xval : 1'b1);
         end else begin : g_tail
            assign frame[j] = (xen && (LEN_W'(j) == xpos)) ? xval : 1'b1;
         end
      end
   endgenerate

   assign len = LEN_W'(2) + dw + LEN_W'(xen) + LEN_W'(fmt.two_stop);

endmodule

// File: rtl/frame_tx_shift.sv
module frame_tx_shift #(
   parameter int FRAME_W = 12,
   parameter int LEN_W   = $clog2(FRAME_W + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load_req,
   input  logic               bit_tick,
   input  logic [FRAME_W-1:0] frame_in,
   input  logic [LEN_W-1:0]   len_in,
   output logic               txd,
   output logic               busy
);

   logic [FRAME_W-1:0] sh_q;
   logic [LEN_W-1:0]   cnt_q;
   logic               busy_q;
   logic               txd_q;
   logic               accept;

   assign accept = load_req & ~busy_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_q   <= '1;
         cnt_q  <= '0;
         busy_q <= 1'b0;
         txd_q  <= 1'b1;
      end else if (accept) begin
         sh_q   <= frame_in;
         cnt_q  <= len_in;
         busy_q <= 1'b1;
      end else if (busy_q && bit_tick) begin
         if (cnt_q != '0) begin
            txd_q <= sh_q[0];
            sh_q  <= {1'b1, sh_q[FRAME_W-1:1]};
            cnt_q <= cnt_q - LEN_W'(1);
         end else begin
            busy_q <= 1'b0;
         end
      end
   end

   assign txd  = txd_q;
   assign busy = busy_q;

   AST_LOAD_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (load_req && !busy_q) |=> busy_q);                                // R9
   AST_DRAIN_CLEARS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && bit_tick && cnt_q == '0) |=> !busy_q);                 // R9
   AST_BUSY_IGNORES_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !bit_tick) |=> ($stable(sh_q) && $stable(cnt_q)));     // R10
   AST_LINE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_tick |=> $stable(txd_q));                                    // R8
   AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q |-> txd_q);                                               // R1
   AST_STOP_BEFORE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_q) |-> txd_q);                                         // R5

endmodule

// File: rtl/frame_tx.sv
module frame_tx
   import frame_tx_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter bit PAR_CHAIN = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] load_data,
   input  logic [2:0]        fmt_sel,
   input  logic              mp_en,
   input  logic              mp_flag,
   input  logic              par_odd,
   input  logic              bit_tick,
   output logic              txd,
   output logic              busy,
   output logic              tx_empty
);

   localparam int FRAME_W = DATA_W + 4;
   localparam int LEN_W   = $clog2(FRAME_W + 1);

   generate
      if (DATA_W < 2 || DATA_W > 16) begin : g_bad_width
         $error("frame_tx: DATA_W must lie in 2..16");
      end
   endgenerate

   fmt_t               fmt;
   logic [FRAME_W-1:0] frame;
   logic [LEN_W-1:0]   len;

   assign fmt = decode_fmt(fmt_sel);

   frame_tx_build #(
      .DATA_W    (DATA_W),
      .PAR_CHAIN (PAR_CHAIN),
      .FRAME_W   (FRAME_W),
      .LEN_W     (LEN_W)
   ) u_build (
      .data    (load_data),
      .fmt     (fmt),
      .mp_en   (mp_en),
      .mp_flag (mp_flag),
      .par_odd (par_odd),
      .frame   (frame),
      .len     (len)
   );

   frame_tx_shift #(
      .FRAME_W (FRAME_W),
      .LEN_W   (LEN_W)
   ) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_req (load),
      .bit_tick (bit_tick),
      .frame_in (frame),
      .len_in   (len),
      .txd      (txd),
      .busy     (busy)
   );

   assign tx_empty = ~busy;

endmodule

// File: tb/test_frame_tx.sv
`timescale 1ns/1ps
module test_frame_tx;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       load = 1'b0;
   logic [7:0] load_data = 8'h00;
   logic [2:0] fmt_sel = 3'b000;
   logic       mp_en = 1'b0;
   logic       mp_flag = 1'b0;
   logic       par_odd = 1'b0;
   logic       bit_tick = 1'b0;
   logic       txd;
   logic       busy;
   logic       tx_empty;

   int vectors = 0;
   int miscompares = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   frame_tx i_frame_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .load_data (load_data),
      .fmt_sel   (fmt_sel),
      .mp_en     (mp_en),
      .mp_flag   (mp_flag),
      .par_odd   (par_odd),
      .bit_tick  (bit_tick),
      .txd       (txd),
      .busy      (busy),
      .tx_empty  (tx_empty)
   );

   task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // Expected frame from the requirements: returns the bit count
   function automatic int expect_frame(input logic [7:0] d, input logic [2:0] f, input logic mp,
                                       input logic flag, input logic odd, output logic [11:0] bits);
      int n = 0;
      int dw;
      logic p;
      bits = '1;
      bits[n] = 1'b0; n++;
      dw = f[2] ? 8 : 7;
      p = odd;
      for (int i = 0; i < dw; i++) begin
         bits[n] = d[i];
         p = p ^ d[i];
         n++;
      end
      if (mp) begin
         bits[n] = flag; n++;
      end else if (f[1]) begin
         bits[n] = p; n++;
      end
      n += f[0] ? 2 : 1;
      return n;
   endfunction

   task automatic pulse_tick();
      bit_tick = 1'b1;
      @(negedge clk);
      bit_tick = 1'b0;
   endtask

   // poke_at >= 0: at that bit, try a second load with changed settings
   task automatic run_frame(input string req, input logic [7:0] d, input logic [2:0] f,
                            input logic mp, input logic flag, input logic odd, input int poke_at);
      logic [11:0] bits;
      int n;
      n = expect_frame(d, f, mp, flag, odd, bits);
      load_data = d; fmt_sel = f; mp_en = mp; mp_flag = flag; par_odd = odd;
      load = 1'b1;
      @(negedge clk);
      load = 1'b0;
      check("R9", "busy after load", busy, 1);
      check("R9", "tx_empty after load", tx_empty, 0);
      check("R8", "line before first tick", txd, 1);
      for (int k = 0; k < n; k++) begin
         if (k == poke_at) begin
            load_data = ~d; fmt_sel = ~f; mp_en = ~mp; mp_flag = ~flag; par_odd = ~odd;
            load = 1'b1;
            @(negedge clk);
            load = 1'b0;
         end
         pulse_tick();
         check(req, $sformatf("bit %0d", k), txd, bits[k]);
         @(negedge clk);
         @(negedge clk);
         check("R8", $sformatf("bit %0d held", k), txd, bits[k]);
         check("R9", $sformatf("busy during bit %0d", k), busy, 1);
      end
      pulse_tick();
      check("R9", "busy after last stop", busy, 0);
      check("R9", "tx_empty after last stop", tx_empty, 1);
      check("R1", "idle line", txd, 1);
   endtask

   task automatic test_reset();
      check("R1", "reset txd", txd, 1);
      check("R1", "reset busy", busy, 0);
      check("R1", "reset tx_empty", tx_empty, 1);
   endtask

   task automatic test_all_codes();
      for (int c = 0; c < 8; c++) begin
         run_frame("R2/R3/R4/R5", 8'hA5 ^ 8'(c * 37), 3'(c), 1'b0, 1'b0, 1'b0, -1);
      end
   endtask

   task automatic test_top_bit_hidden();
      run_frame("R2", 8'h80, 3'b000, 1'b0, 1'b0, 1'b0, -1);
      run_frame("R2/R3", 8'hC1, 3'b010, 1'b0, 1'b0, 1'b0, -1);
   endtask

   task automatic test_odd_parity();
      run_frame("R3", 8'h3C, 3'b110, 1'b0, 1'b0, 1'b1, -1);
      run_frame("R3", 8'h01, 3'b011, 1'b0, 1'b0, 1'b1, -1);
   endtask

   task automatic test_mp_mode();
      run_frame("R6/R7", 8'h5A, 3'b111, 1'b1, 1'b1, 1'b0, -1);
      run_frame("R6/R7", 8'h07, 3'b010, 1'b1, 1'b0, 1'b1, -1);
      run_frame("R6/R7", 8'hFF, 3'b100, 1'b1, 1'b0, 1'b0, -1);
      run_frame("R6/R7", 8'h80, 3'b001, 1'b1, 1'b1, 1'b0, -1);
   endtask

   task automatic test_busy_load();
      run_frame("R10/R11", 8'h96, 3'b110, 1'b0, 1'b0, 1'b0, 3);
      run_frame("R10/R11", 8'h2B, 3'b001, 1'b1, 1'b1, 1'b0, 0);
      // no second frame may follow the ignored load
      pulse_tick();
      pulse_tick();
      check("R10", "no frame after ignored load", busy, 0);
      check("R10", "line idle after ignored load", txd, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      test_reset();
      test_all_codes();
      test_top_bit_hidden();
      test_odd_parity();
      test_mp_mode();
      test_busy_load();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      #1000000;
      if (!done) begin
         done = 1'b1;
         miscompares++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

endmodule